// File: doc/BRIEF.md
# Audio Playback Rate Controller

This block sits on the PCM sample path between an audio frame decoder and the output filter and sets the playback speed one frame at a time. Every decoded frame carries a fixed number of samples. In normal play each of them is passed on unchanged. In fast play one sample out of each group of twelve is dropped, so the filter receives eleven twelfths of the frame. In slow play the last sample of each group of twelve is sent twice, so the filter receives thirteen twelfths of the frame. Pause stops all traffic and holds every piece of state.

A host writes a two-bit speed field. The normal, fast and slow settings are taken up at the next frame boundary. Pause acts at once. A fast or slow setting covers exactly one frame. When that frame's last input sample is accepted, the hardware sets the field back to normal. The host can poll the field to learn that the adjusted frame is done. If a host write falls in the same cycle as the automatic revert, the host write wins. While paused, the block drops its request to the bitstream parser and freezes all counters, so resuming keeps the frame position and bitstream alignment exactly as they were.

Both sample interfaces use valid/ready handshakes. A start flag travels with the first sample of each frame.

Top module: `play_rate_ctrl`

## Requirements
- R1: After reset the speed field reads 2'b01 (normal), out_valid is low, parse_req is high and in_ready is high.
- R2: In normal play (field 2'b01) every input sample is forwarded in order with unchanged data. The first sample of the frame carries out_start=1 and every other sample carries out_start=0.
- R3: In fast play (field 2'b10) the sample at frame position p with p mod 12 = 11 is accepted but not forwarded. A frame of FRAME_LEN samples therefore yields FRAME_LEN - FRAME_LEN/12 outputs.
- R4: In slow play (field 2'b11) the sample at frame position p with p mod 12 = 11 is forwarded twice in a row, the repeat with out_start=0. A frame yields FRAME_LEN + FRAME_LEN/12 outputs.
- R5: In the cycle after the last sample (position FRAME_LEN-1) of a fast or slow frame is accepted, the field reads 2'b01 unless the host wrote it in that same cycle.
- R6: A host write of normal, fast or slow made in the middle of a frame does not change that frame's treatment. It applies from the next sample at frame position 0. After a normal frame the field is not rewritten.
- R7: When a host write and the automatic revert fall in the same cycle, the field takes the host's value.
- R8: While the field reads 2'b00 (pause), out_valid, in_ready and parse_req are all low. A sample held at the output at the moment of pausing is delivered after play resumes, and no sample is lost or duplicated.
- R9: While out_valid is high and out_ready is low, out_data and out_start keep their values into the next cycle.
- R10: An accepted sample with in_start=1 is taken as frame position 0, whatever the position counter held. It also starts a new frame that uses the current field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the speed field |
| host_mode | input | 2 | Value written: 00 pause, 01 normal, 10 fast, 11 slow |
| mode_rd | output | 2 | Current speed field, including hardware revert |
| parse_req | output | 1 | Request to the upstream parser, low in pause |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | DATA_W | Signed PCM input sample |
| in_start | input | 1 | Marks the first sample of a frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Filter accepts the output sample |
| out_data | output | DATA_W | Signed PCM output sample |
| out_start | output | 1 | Marks the first output of a frame |

## Verification
The bound checker checks four things on every cycle. Pause silences out_valid, in_ready and parse_req. A stalled output holds its data. A host write always lands in the field. The field returns to normal once a fast or slow frame ends. Other behaviour only shows over whole frames, so only the bench's scenarios can reveal it: which positions are dropped or doubled, that mid-frame writes are deferred to the next frame, that in_start realigns the position counter, and that a sample parked across a pause is still delivered. The bench runs a scoreboard under random output back-pressure to cover these.

// File: rtl/prc_pkg.sv
// Shared definitions for the playback rate controller.
// Assumes: the two-bit speed field encoding below is fixed by the host software.
package prc_pkg;
    typedef enum logic [1:0] {
        PM_PAUSE  = 2'b00,
        PM_NORMAL = 2'b01,
        PM_FAST   = 2'b10,
        PM_SLOW   = 2'b11
    } play_mode_e;
endpackage

// File: rtl/prc_mode_reg.sv
// Speed field register. Holds the host-visible play mode and clears a
// one-shot fast/slow setting back to normal when the hardware asks.
// Assumes: a host write in the same cycle as a revert request takes priority.
module prc_mode_reg
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  play_mode_e host_mode,
    input  logic       revert,
    output play_mode_e mode_q
);

    // Field update: reset to normal, host write first, then hardware revert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_NORMAL;
        end else if (host_wr) begin
            mode_q <= host_mode;
        end else if (revert) begin
            mode_q <= PM_NORMAL;
        end
    end

endmodule

// File: rtl/prc_frame_seq.sv
// Frame position tracker. Counts accepted samples within a frame and the
// phase within each group, latches the mode that governs the frame, and
// decides per sample whether it is dropped, repeated, first or last.
// Assumes: accept is only raised when the sample is really taken;
// in_start forces frame position zero.
module prc_frame_seq
    import prc_pkg::*;
#(
    parameter int FRAME_LEN = 1152,
    parameter int GROUP     = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       in_start,
    input  play_mode_e mode_q,
    output play_mode_e eff_mode,
    output logic       first_o,
    output logic       last_o,
    output logic       drop_o,
    output logic       rep_o
);

    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int PH_W  = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(GROUP - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph;
    play_mode_e       fmode_q;
    logic             group_end;

    // Position of the offered sample and its per-sample decisions.
    always_comb begin
        idx       = in_start ? '0 : cnt_q;
        first_o   = (idx == '0);
        ph        = first_o ? '0 : ph_q;
        eff_mode  = first_o ? mode_q : fmode_q;
        group_end = (ph == PH_LAST);
        last_o    = (idx == LAST_IDX);
        drop_o    = (eff_mode == PM_FAST) && group_end;
        rep_o     = (eff_mode == PM_SLOW) && group_end;
    end

    // Advance position and phase on each accepted sample; latch frame mode at position zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ph_q    <= '0;
            fmode_q <= PM_NORMAL;
        end else if (accept) begin
            cnt_q <= last_o ? '0 : idx + 1'b1;
            ph_q  <= group_end ? '0 : ph + 1'b1;
            if (first_o) begin
                fmode_q <= mode_q;
            end
        end
    end

endmodule

// File: rtl/prc_out_stage.sv
// One-entry output register with a repeat flag. Loads a sample, and when
// asked to repeat it keeps the sample valid for a second handshake.
// Freezes completely while hold is high.
// Assumes: load is only raised when can_take is high.
module prc_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic              rep_in,
    input  logic              start_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_start,
    output logic              can_take
);

    logic vld_q;
    logic rep_q;
    logic fire;

    // Handshake view of the register, masked while held.
    always_comb begin
        out_valid = vld_q && !hold;
        fire      = out_valid && out_ready;
        can_take  = !hold && !rep_q && (!vld_q || out_ready);
    end

    // Register update: repeat pass, new load, or emptying after a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q     <= 1'b0;
            rep_q     <= 1'b0;
            out_data  <= '0;
            out_start <= 1'b0;
        end else if (!hold) begin
            if (rep_q && fire) begin
                rep_q     <= 1'b0;
                out_start <= 1'b0;
            end else if (load) begin
                vld_q     <= 1'b1;
                rep_q     <= rep_in;
                out_data  <= data_in;
                out_start <= start_in;
            end else if (fire) begin
                vld_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/play_rate_ctrl.sv
// Playback rate controller top. Passes PCM samples from a frame decoder
// to the output filter, dropping or repeating one sample per group of
// twelve in fast or slow frames, and stalling everything in pause.
// Assumes: fast/slow/normal writes apply at the next frame start; pause is immediate.
module play_rate_ctrl
    import prc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 1152,
    parameter int GROUP     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_mode,
    output logic [1:0]        mode_rd,
    output logic              parse_req,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_start,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_start
);

    play_mode_e mode_q;
    play_mode_e eff_mode;
    logic       paused;
    logic       accept;
    logic       first;
    logic       last;
    logic       drop;
    logic       rep;
    logic       end_fire;
    logic       revert;
    logic       can_take;

    // Glue: pause detection, accept, frame end and revert request.
    always_comb begin
        paused    = (mode_q == PM_PAUSE);
        accept    = in_valid && can_take;
        end_fire  = accept && last;
        revert    = end_fire && ((eff_mode == PM_FAST) || (eff_mode == PM_SLOW));
        in_ready  = can_take;
        parse_req = !paused;
        mode_rd   = mode_q;
    end

    prc_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_mode(play_mode_e'(host_mode)),
        .revert   (revert),
        .mode_q   (mode_q)
    );

    prc_frame_seq #(
        .FRAME_LEN(FRAME_LEN),
        .GROUP    (GROUP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .in_start(in_start),
        .mode_q  (mode_q),
        .eff_mode(eff_mode),
        .first_o (first),
        .last_o  (last),
        .drop_o  (drop),
        .rep_o   (rep)
    );

    prc_out_stage #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (paused),
        .load     (accept && !drop),
        .rep_in   (rep),
        .start_in (first),
        .data_in  (in_data),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_start(out_start),
        .can_take (can_take)
    );

endmodule

// File: rtl/prc_chk.sv
// Property checker for the playback rate controller, bound to the top.
module prc_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [1:0]        host_mode,
    input logic [1:0]        mode_rd,
    input logic              parse_req,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_start,
    input logic              end_fire,
    input logic [1:0]        eff_mode
);

    // R8
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b00) |-> (!out_valid && !in_ready && !parse_req));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_start)));

    // R7
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (mode_rd == $past(host_mode)));

    // R5
    one_shot_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire && eff_mode[1] && !host_wr) |=> (mode_rd == 2'b01));

endmodule

bind play_rate_ctrl prc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (host_wr),
    .host_mode(host_mode),
    .mode_rd  (mode_rd),
    .parse_req(parse_req),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_start(out_start),
    .end_fire (end_fire),
    .eff_mode (eff_mode)
);

// File: tb/tb_play_rate_ctrl.sv
module tb_play_rate_ctrl;
    localparam int FL = 48;
    localparam int GR = 12;
    localparam int DW = 16;
    localparam logic [1:0] M_PAUSE = 2'b00;
    localparam logic [1:0] M_NORM  = 2'b01;
    localparam logic [1:0] M_FAST  = 2'b10;
    localparam logic [1:0] M_SLOW  = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [1:0]    host_mode = 2'b01;
    logic [1:0]    mode_rd;
    logic          parse_req;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_start = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_start;

    play_rate_ctrl #(.DATA_W(DW), .FRAME_LEN(FL), .GROUP(GR)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_mode(host_mode),
        .mode_rd(mode_rd), .parse_req(parse_req), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_start(in_start),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_start(out_start)
    );

    typedef struct packed {
        logic [DW-1:0] d;
        logic          s;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    logic  bp_en = 1'b0;
    logic  hold_low = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Output back-pressure pattern.
    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= hold_low ? 1'b0 : (!bp_en ? 1'b1 : (lfsr[0] | lfsr[2]));
    end

    // Monitor: scoreboard compare and stall stability (R9).
    logic          stall_prev = 1'b0;
    logic [DW-1:0] prev_d = '0;
    logic          prev_s = 1'b0;
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (stall_prev && out_valid) begin
                chk(out_data == prev_d && out_start == prev_s, "R9",
                    "held data", int'(out_data), int'(prev_d));
            end
            stall_prev = out_valid && !out_ready;
            prev_d     = out_data;
            prev_s     = out_start;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected output", int'(out_data), -1);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(out_data == e.d, cur_req, "data", int'(out_data), int'(e.d));
                    chk(out_start == e.s, cur_req, "start flag", int'(out_start), int'(e.s));
                end
            end
        end
    end

    task automatic host_write(input logic [1:0] m);
        @(negedge clk);
        host_wr   = 1'b1;
        host_mode = m;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    // Driver: push expected outputs, then hand the sample over.
    task automatic send_sample(input int k, input logic [1:0] m, input logic [DW-1:0] d,
                               input bit hw, input logic [1:0] hm);
        bit took;
        item_t e;
        e.d = d;
        e.s = (k == 0);
        if (!(m == M_FAST && (k % GR) == GR - 1)) exp_q.push_back(e);
        if (m == M_SLOW && (k % GR) == GR - 1) begin
            e.s = 1'b0;
            exp_q.push_back(e);
        end
        took = 1'b0;
        while (!took) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = d;
            in_start  = (k == 0);
            host_wr   = hw;
            host_mode = hm;
            #1;
            took = in_ready;
            @(posedge clk);
        end
        #1;
        in_valid = 1'b0;
        in_start = 1'b0;
        host_wr  = 1'b0;
    endtask

    task automatic send_range(input int base, input logic [1:0] m, input int from, input int to);
        for (int k = from; k <= to; k++) begin
            send_sample(k, m, DW'(base + k * 7), 1'b0, M_NORM);
        end
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() > 0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        #3;
        chk(exp_q.size() == 0, cur_req, "items left undelivered", exp_q.size(), 0);
    endtask

    task automatic mode_is(input logic [1:0] m, input string req);
        @(negedge clk);
        #2;
        chk(mode_rd == m, req, "mode field", int'(mode_rd), int'(m));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog %s actual=hung expected=done", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1 reset state
        chk(mode_rd == M_NORM, "R1", "mode after reset", int'(mode_rd), 1);
        chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(parse_req, "R1", "parse_req after reset", int'(parse_req), 1);
        chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

        // R2 normal frame under back-pressure
        cur_req = "R2";
        bp_en = 1'b1;
        send_range(1000, M_NORM, 0, FL - 1);
        drain();

        // R3 fast frame, then R5 revert
        cur_req = "R3";
        host_write(M_FAST);
        send_range(3000, M_FAST, 0, FL - 1);
        mode_is(M_NORM, "R5");
        drain();

        // R4 slow frame, then R5 revert
        cur_req = "R4";
        host_write(M_SLOW);
        send_range(5000, M_SLOW, 0, FL - 1);
        mode_is(M_NORM, "R5");
        drain();

        // R6 mid-frame write deferred to next frame
        cur_req = "R6";
        send_range(7000, M_NORM, 0, 19);
        host_write(M_FAST);
        send_range(7000, M_NORM, 20, FL - 1);
        mode_is(M_FAST, "R6");
        send_range(9000, M_FAST, 0, FL - 1);
        mode_is(M_NORM, "R6");
        drain();

        // R7 host write collides with revert
        cur_req = "R7";
        host_write(M_FAST);
        send_range(11000, M_FAST, 0, FL - 2);
        send_sample(FL - 1, M_FAST, DW'(11000 + (FL - 1) * 7), 1'b1, M_SLOW);
        mode_is(M_SLOW, "R7");
        send_range(13000, M_SLOW, 0, FL - 1);
        mode_is(M_NORM, "R7");
        drain();

        // R10 in_start realigns position mid-count
        cur_req = "R10";
        send_range(15000, M_NORM, 0, 16);
        host_write(M_FAST);
        send_range(17000, M_FAST, 0, FL - 1);
        mode_is(M_NORM, "R10");
        drain();

        // R8 pause with a sample parked at the output
        cur_req = "R8";
        send_range(19000, M_NORM, 0, 9);
        hold_low = 1'b1;
        repeat (3) @(negedge clk);
        host_write(M_PAUSE);
        #2;
        chk(!out_valid, "R8", "out_valid in pause", int'(out_valid), 0);
        chk(!in_ready, "R8", "in_ready in pause", int'(in_ready), 0);
        chk(!parse_req, "R8", "parse_req in pause", int'(parse_req), 0);
        hold_low = 1'b0;
        repeat (20) @(negedge clk);
        #2;
        chk(!out_valid && !in_ready, "R8", "still quiet in pause",
            int'({out_valid, in_ready}), 0);
        chk(mode_rd == M_PAUSE, "R8", "mode stays pause", int'(mode_rd), 0);
        chk(exp_q.size() > 0, "R8", "parked sample still owed", exp_q.size(), 1);
        host_write(M_NORM);
        send_range(19000, M_NORM, 10, FL - 1);
        drain();
        mode_is(M_NORM, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule